// File: doc/BRIEF.md
# Ball-Machine Instruction Sequencer

This block is the control unit of a small accumulator machine whose memory loses a word when it is read. It walks a fixed chain of steps for every instruction (fetch, write-back of the fetched word, operand transfer, store and program-counter advance). In each step it drives a set of discrete control lines towards the memory, the two regenerators, the injector, the path diverter and the two registers. The datapath reports the end of each mechanical step on `step_done`, and the sequencer moves on only then.

The instruction word carries a 5-bit operand address in bits 4..0 and a 3-bit opcode in bits 7..5. The opcode bits reach the sequencer on `op_in` during the dispatch step. A single priority-resolved path selector drives the diverter. When it has no request, the word falls into the default split, where the address field feeds the address sender and the opcode field feeds the instruction decoder. The opcodes are 000 jump absolute, 001 jump relative, 010 load negated, 011 store, 100 and 101 subtract, 110 skip-if-negative and 111 halt.

Top module: `bmseq_top`

## Requirements
- R1: After reset all control lines are low, both regenerator modes are neutral, `route` is 5'b00001 (default split) and `halted` is low. The first accepted step starts a fetch with `inj_all` high and `route` 5'b00010.
- R2: The step only changes on a clock edge where `step_done` is high. While `step_done` is low, every output keeps its value.
- R3: Fetch runs in six steps. First, PC-read route with `inj_all`. Second, middle regenerator release on the PC-read route. Third, `line_open`. Fourth, middle copy with `mem_reset`. Fifth, `sender_rel`. Sixth, middle release on the default split.
- R4: Operand route, taken in the step where the operand word leaves memory: opcodes 000 and 001 give the PC-update route 5'b00100, 010, 100 and 101 give the accumulator-update route 5'b01000, 110 gives the accumulator-read route 5'b10000, and 011 gives the split 5'b00001.
- R5: `route` is one-hot with bit 4 accumulator read, bit 3 accumulator update, bit 2 PC update, bit 1 PC read and bit 0 default split. Among simultaneous requests the lowest-numbered position in that list wins.
- R6: Load negated raises `acc_clr` and jump absolute raises `pc_clr`, each for one step that comes before the operand read. No other opcode raises either line.
- R7: Store raises `discard` for the three operand steps and puts the lower regenerator in copy mode (01) once. No other opcode does either.
- R8: Skip-if-negative adds one `acc_probe` step before the advance and samples `acc_sign` there. `pc_skip` is high in the advance step exactly when that sample was 1.
- R9: Each instruction ends with one advance step in which `pc_inc`, `sender_rel` and `idec_clr` are all high. Instructions last 14 steps, or 15 for skip-if-negative.
- R10: Opcode 111 moves the block into a halted state right after dispatch. There `halted` stays high, no further control is issued, and only reset leaves it.
- R11: Regenerator modes are encoded 00 neutral, 01 copy, 10 release, and 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_done | input | 1 | Datapath has finished the current step |
| op_in | input | 3 | Opcode field (instruction bits 7..5) from the instruction decoder |
| acc_sign | input | 1 | Accumulator bit 7 as seen through the read path |
| route | output | 5 | One-hot diverter path select |
| rod_hold | output | 1 | Hold all address-decoder rods raised |
| line_open | output | 1 | Release the selected memory line (read or capture) |
| mem_reset | output | 1 | Push all memory rows back to storage position |
| inj_all | output | 1 | Inject a bearing into every data channel |
| mid_mode | output | 2 | Middle regenerator mode |
| low_mode | output | 2 | Lower regenerator mode |
| discard | output | 1 | Drop data leaving memory |
| acc_clr | output | 1 | Clear the accumulator |
| pc_clr | output | 1 | Clear the program counter |
| acc_probe | output | 1 | Inject the sign probe into the accumulator read path |
| pc_inc | output | 1 | Normal program-counter increment |
| pc_skip | output | 1 | Extra increment for a taken skip |
| sender_rel | output | 1 | Release the address sender |
| idec_clr | output | 1 | Reset the instruction decoder |
| halted | output | 1 | Machine is halted |

## Verification
The normal program-counter increment and the extra skip increment can fall in the same advance step. That step also carries the sender release and the decoder reset. A skip-if-negative instruction is run with `acc_sign` held high and again held low. The recorded advance step must show `pc_inc` and `pc_skip` together in the first case and `pc_inc` alone in the second. The instruction length must also grow by exactly the one probe step.

// File: rtl/bmseq_pkg.sv
`timescale 1ns/1ps
package bmseq_pkg;

    localparam int OP_W    = 3;
    localparam int NUM_OPS = 1 << OP_W;
    localparam int NREQ    = 4;
    localparam int ROUTE_W = NREQ + 1;

    localparam logic [OP_W-1:0] OPC_JMP  = 3'd0;
    localparam logic [OP_W-1:0] OPC_JRP  = 3'd1;
    localparam logic [OP_W-1:0] OPC_LDN  = 3'd2;
    localparam logic [OP_W-1:0] OPC_STO  = 3'd3;
    localparam logic [OP_W-1:0] OPC_SUBA = 3'd4;
    localparam logic [OP_W-1:0] OPC_SUBB = 3'd5;
    localparam logic [OP_W-1:0] OPC_CMP  = 3'd6;
    localparam logic [OP_W-1:0] OPC_HLT  = 3'd7;

    typedef enum logic [4:0] {
        PH_BOOT, PH_F_INJ, PH_F_ADDR, PH_F_READ, PH_F_COPY, PH_F_SPLIT,
        PH_F_DISP, PH_O_SET, PH_O_READ, PH_O_COPY, PH_O_DROP, PH_S_INJ,
        PH_S_WRITE, PH_S_DONE, PH_PROBE, PH_ADV, PH_HALT
    } phase_e;

    typedef enum logic [1:0] {
        RG_NEUTRAL = 2'd0,
        RG_COPY    = 2'd1,
        RG_RELEASE = 2'd2
    } regen_e;

    typedef struct packed {
        logic   req_acc_rd;
        logic   req_acc_upd;
        logic   req_pc_upd;
        logic   req_pc_rd;
        logic   rod_hold;
        logic   line_open;
        logic   mem_reset;
        logic   inj_all;
        regen_e mid;
        regen_e low;
        logic   discard;
        logic   acc_clr;
        logic   pc_clr;
        logic   acc_probe;
        logic   pc_inc;
        logic   pc_skip;
        logic   sender_rel;
        logic   idec_clr;
        logic   halted;
    } ctl_t;

endpackage

// File: rtl/bmseq_opdec.sv
`timescale 1ns/1ps
module bmseq_opdec #(
    parameter int OPW  = 3,
    localparam int NOP = 1 << OPW
) (
    input  logic [OPW-1:0] op,
    output logic [NOP-1:0] sel
);
    for (genvar i = 0; i < NOP; i++) begin : g_line
        assign sel[i] = (op == OPW'(i));
    end
endmodule

// File: rtl/bmseq_route.sv
`timescale 1ns/1ps
module bmseq_route #(
    parameter int NR = 4
) (
    input  logic [NR-1:0] req,
    output logic [NR:0]   route
);
    // Higher request index wins; no request selects the default split.
    for (genvar i = 0; i < NR; i++) begin : g_pri
        assign route[i+1] = req[i] & ~(|(req >> (i + 1)));
    end
    assign route[0] = ~(|req);
endmodule

// File: rtl/bmseq_ctlgen.sv
`timescale 1ns/1ps
module bmseq_ctlgen
    import bmseq_pkg::*;
#(
    parameter int NOP = 8
) (
    input  phase_e         ph,
    input  logic [NOP-1:0] opsel,
    input  logic           skip,
    output ctl_t           ctl
);
    logic is_acc_upd, is_pc_upd, is_cmp, is_sto;
    logic unused_hlt;

    assign is_acc_upd = opsel[OPC_LDN] | opsel[OPC_SUBA] | opsel[OPC_SUBB];
    assign is_pc_upd  = opsel[OPC_JMP] | opsel[OPC_JRP];
    assign is_cmp     = opsel[OPC_CMP];
    assign is_sto     = opsel[OPC_STO];
    assign unused_hlt = opsel[OPC_HLT];

    always_comb begin
        ctl     = '0;
        ctl.mid = RG_NEUTRAL;
        ctl.low = RG_NEUTRAL;
        case (ph)
            PH_F_INJ: begin
                ctl.req_pc_rd = 1'b1;
                ctl.rod_hold  = 1'b1;
                ctl.inj_all   = 1'b1;
            end
            PH_F_ADDR: begin
                ctl.req_pc_rd = 1'b1;
                ctl.rod_hold  = 1'b1;
                ctl.mid       = RG_RELEASE;
            end
            PH_F_READ:  ctl.line_open = 1'b1;
            PH_F_COPY: begin
                ctl.mid       = RG_COPY;
                ctl.mem_reset = 1'b1;
            end
            PH_F_SPLIT: begin
                ctl.rod_hold   = 1'b1;
                ctl.sender_rel = 1'b1;
            end
            PH_F_DISP: begin
                ctl.rod_hold = 1'b1;
                ctl.mid      = RG_RELEASE;
            end
            PH_O_SET, PH_O_READ, PH_O_COPY: begin
                ctl.req_acc_upd = is_acc_upd;
                ctl.req_pc_upd  = is_pc_upd;
                ctl.req_acc_rd  = is_cmp;
                ctl.discard     = is_sto;
                if (ph == PH_O_SET) begin
                    ctl.acc_clr = opsel[OPC_LDN];
                    ctl.pc_clr  = opsel[OPC_JMP];
                end
                if (ph == PH_O_READ) ctl.line_open = 1'b1;
                if (ph == PH_O_COPY) begin
                    ctl.mid       = RG_COPY;
                    ctl.mem_reset = 1'b1;
                end
            end
            PH_O_DROP:  ctl.low = RG_RELEASE;
            PH_S_INJ: begin
                ctl.req_acc_rd = 1'b1;
                ctl.inj_all    = 1'b1;
                ctl.mid        = RG_RELEASE;
            end
            PH_S_WRITE: begin
                ctl.line_open = 1'b1;
                ctl.low       = is_sto ? RG_COPY : RG_NEUTRAL;
            end
            PH_S_DONE: begin
                ctl.low       = RG_RELEASE;
                ctl.mem_reset = 1'b1;
            end
            PH_PROBE: begin
                ctl.req_acc_rd = 1'b1;
                ctl.acc_probe  = 1'b1;
            end
            PH_ADV: begin
                ctl.pc_inc     = 1'b1;
                ctl.pc_skip    = skip;
                ctl.sender_rel = 1'b1;
                ctl.idec_clr   = 1'b1;
            end
            PH_HALT:    ctl.halted = 1'b1;
            default:    ctl = '0;
        endcase
    end
endmodule

// File: rtl/bmseq_top.sv
`timescale 1ns/1ps
module bmseq_top
    import bmseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_done,
    input  logic [OP_W-1:0] op_in,
    input  logic            acc_sign,
    output logic [ROUTE_W-1:0] route,
    output logic            rod_hold,
    output logic            line_open,
    output logic            mem_reset,
    output logic            inj_all,
    output logic [1:0]      mid_mode,
    output logic [1:0]      low_mode,
    output logic            discard,
    output logic            acc_clr,
    output logic            pc_clr,
    output logic            acc_probe,
    output logic            pc_inc,
    output logic            pc_skip,
    output logic            sender_rel,
    output logic            idec_clr,
    output logic            halted
);
    typedef struct packed {
        phase_e          ph;
        logic [OP_W-1:0] op;
        logic            skip;
    } st_t;

    st_t  st_d, st_q;
    ctl_t ctl_d, ctl_q;
    logic [NUM_OPS-1:0] sel_d;

    always_comb begin
        st_d = st_q;
        if (step_done) begin
            case (st_q.ph)
                PH_BOOT:    st_d.ph = PH_F_INJ;
                PH_F_INJ:   st_d.ph = PH_F_ADDR;
                PH_F_ADDR:  st_d.ph = PH_F_READ;
                PH_F_READ:  st_d.ph = PH_F_COPY;
                PH_F_COPY:  st_d.ph = PH_F_SPLIT;
                PH_F_SPLIT: st_d.ph = PH_F_DISP;
                PH_F_DISP: begin
                    st_d.op = op_in;
                    st_d.ph = (op_in == OPC_HLT) ? PH_HALT : PH_O_SET;
                end
                PH_O_SET:   st_d.ph = PH_O_READ;
                PH_O_READ:  st_d.ph = PH_O_COPY;
                PH_O_COPY:  st_d.ph = PH_O_DROP;
                PH_O_DROP:  st_d.ph = PH_S_INJ;
                PH_S_INJ:   st_d.ph = PH_S_WRITE;
                PH_S_WRITE: st_d.ph = PH_S_DONE;
                PH_S_DONE:  st_d.ph = (st_q.op == OPC_CMP) ? PH_PROBE : PH_ADV;
                PH_PROBE: begin
                    st_d.skip = acc_sign;
                    st_d.ph   = PH_ADV;
                end
                PH_ADV: begin
                    st_d.skip = 1'b0;
                    st_d.ph   = PH_F_INJ;
                end
                PH_HALT:    st_d.ph = PH_HALT;
                default:    st_d.ph = PH_BOOT;
            endcase
        end
    end

    bmseq_opdec #(.OPW(OP_W)) u_dec (
        .op  (st_d.op),
        .sel (sel_d)
    );

    bmseq_ctlgen #(.NOP(NUM_OPS)) u_ctl (
        .ph    (st_d.ph),
        .opsel (sel_d),
        .skip  (st_d.skip),
        .ctl   (ctl_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '{ph: PH_BOOT, op: '0, skip: 1'b0};
            ctl_q <= '0;
        end else begin
            st_q  <= st_d;
            ctl_q <= ctl_d;
        end
    end

    bmseq_route #(.NR(NREQ)) u_route (
        .req   ({ctl_q.req_acc_rd, ctl_q.req_acc_upd, ctl_q.req_pc_upd, ctl_q.req_pc_rd}),
        .route (route)
    );

    assign rod_hold   = ctl_q.rod_hold;
    assign line_open  = ctl_q.line_open;
    assign mem_reset  = ctl_q.mem_reset;
    assign inj_all    = ctl_q.inj_all;
    assign mid_mode   = ctl_q.mid;
    assign low_mode   = ctl_q.low;
    assign discard    = ctl_q.discard;
    assign acc_clr    = ctl_q.acc_clr;
    assign pc_clr     = ctl_q.pc_clr;
    assign acc_probe  = ctl_q.acc_probe;
    assign pc_inc     = ctl_q.pc_inc;
    assign pc_skip    = ctl_q.pc_skip;
    assign sender_rel = ctl_q.sender_rel;
    assign idec_clr   = ctl_q.idec_clr;
    assign halted     = ctl_q.halted;
endmodule

// File: rtl/bmseq_checker.sv
`timescale 1ns/1ps
module bmseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       step_done,
    input logic [4:0] route,
    input logic       rod_hold,
    input logic       line_open,
    input logic       mem_reset,
    input logic       inj_all,
    input logic [1:0] mid_mode,
    input logic [1:0] low_mode,
    input logic       discard,
    input logic       acc_clr,
    input logic       pc_clr,
    input logic       acc_probe,
    input logic       pc_inc,
    input logic       pc_skip,
    input logic       sender_rel,
    input logic       idec_clr,
    input logic       halted
);
    logic [19:0] bundle;
    assign bundle = {route, rod_hold, line_open, mem_reset, inj_all, mid_mode,
                     low_mode, discard, acc_clr, pc_clr, acc_probe, pc_inc,
                     pc_skip, sender_rel, idec_clr};

    a_r5_route_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(route) == 1);

    a_r2_hold_without_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_done) |-> $stable(bundle) && $stable(halted));

    a_r9_advance_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> sender_rel && idec_clr);

    a_r8_skip_rides_inc: assert property (@(posedge clk) disable iff (!rst_n)
        pc_skip |-> pc_inc);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !pc_inc && !inj_all && !line_open && !mem_reset);

    a_r11_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mid_mode != 2'b11 && low_mode != 2'b11);

    a_r6_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_clr && pc_clr));
endmodule

bind bmseq_top bmseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_done  (step_done),
    .route      (route),
    .rod_hold   (rod_hold),
    .line_open  (line_open),
    .mem_reset  (mem_reset),
    .inj_all    (inj_all),
    .mid_mode   (mid_mode),
    .low_mode   (low_mode),
    .discard    (discard),
    .acc_clr    (acc_clr),
    .pc_clr     (pc_clr),
    .acc_probe  (acc_probe),
    .pc_inc     (pc_inc),
    .pc_skip    (pc_skip),
    .sender_rel (sender_rel),
    .idec_clr   (idec_clr),
    .halted     (halted)
);

// File: tb/tb_bmseq_top.sv
`timescale 1ns/1ps
module tb_bmseq_top;
    localparam int NREC = 20;
    localparam int NVEC = 8;
    // {op[15:13], sign[12], len[11:8], accclr[7], pcclr[6], disc[5:4], lowcp[3], probe[2], skip[1], spare[0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 4'd14, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd1, 1'b1, 4'd14, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd2, 1'b1, 4'd14, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd3, 1'b0, 4'd14, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd4, 1'b0, 4'd14, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd5, 1'b1, 4'd14, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd6, 1'b1, 4'd15, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd6, 1'b0, 4'd15, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_done = 1'b0;
    logic [2:0] op_in = 3'd0;
    logic acc_sign = 1'b0;
    logic [4:0] route;
    logic rod_hold, line_open, mem_reset, inj_all, discard, acc_clr, pc_clr;
    logic acc_probe, pc_inc, pc_skip, sender_rel, idec_clr, halted;
    logic [1:0] mid_mode, low_mode;

    int n_chk = 0;
    int n_fail = 0;

    logic [4:0] rec_route [NREC];
    logic [1:0] rec_mid [NREC];
    logic [1:0] rec_low [NREC];
    logic rec_inj [NREC], rec_line [NREC], rec_mrst [NREC], rec_disc [NREC];
    logic rec_aclr [NREC], rec_pclr [NREC], rec_probe [NREC], rec_inc [NREC];
    logic rec_skip [NREC], rec_send [NREC], rec_idec [NREC], rec_halt [NREC];

    always #10 clk = ~clk;

    bmseq_top dut (
        .clk(clk), .rst_n(rst_n), .step_done(step_done), .op_in(op_in),
        .acc_sign(acc_sign), .route(route), .rod_hold(rod_hold),
        .line_open(line_open), .mem_reset(mem_reset), .inj_all(inj_all),
        .mid_mode(mid_mode), .low_mode(low_mode), .discard(discard),
        .acc_clr(acc_clr), .pc_clr(pc_clr), .acc_probe(acc_probe),
        .pc_inc(pc_inc), .pc_skip(pc_skip), .sender_rel(sender_rel),
        .idec_clr(idec_clr), .halted(halted)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_op(input logic [2:0] op, input logic sg);
        do_reset();
        op_in = op;
        acc_sign = sg;
        step_done = 1'b1;
        for (int k = 0; k < NREC; k++) begin
            @(posedge clk);
            @(negedge clk);
            rec_route[k] = route;  rec_mid[k] = mid_mode;  rec_low[k] = low_mode;
            rec_inj[k] = inj_all;  rec_line[k] = line_open; rec_mrst[k] = mem_reset;
            rec_disc[k] = discard; rec_aclr[k] = acc_clr;   rec_pclr[k] = pc_clr;
            rec_probe[k] = acc_probe; rec_inc[k] = pc_inc;  rec_skip[k] = pc_skip;
            rec_send[k] = sender_rel; rec_idec[k] = idec_clr; rec_halt[k] = halted;
        end
        step_done = 1'b0;
    endtask

    function automatic logic [4:0] exp_route(input logic [2:0] op);
        case (op)
            3'd0, 3'd1:       return 5'b00100;
            3'd2, 3'd4, 3'd5: return 5'b01000;
            3'd6:             return 5'b10000;
            default:          return 5'b00001;
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4_000_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(route == 5'b00001, "R1 reset route", route, 1);
        chk({rod_hold, line_open, mem_reset, inj_all, discard, acc_clr, pc_clr,
             acc_probe, pc_inc, pc_skip, sender_rel, idec_clr, halted} == '0,
            "R1 reset lines", 1, 0);
        chk(mid_mode == 2'd0 && low_mode == 2'd0, "R1 reset modes", mid_mode, 0);

        // R2: no progress without step_done, outputs held
        repeat (5) @(negedge clk);
        chk(inj_all == 1'b0 && route == 5'b00001, "R2 idle without done", inj_all, 0);
        step_done = 1'b1;
        @(posedge clk); @(negedge clk);
        step_done = 1'b0;
        chk(inj_all == 1'b1 && route == 5'b00010, "R1 first fetch step", route, 2);
        repeat (4) @(negedge clk);
        chk(inj_all == 1'b1 && mid_mode == 2'd0 && route == 5'b00010, "R2 held step", inj_all, 1);
        step_done = 1'b1;
        @(posedge clk); @(negedge clk);
        step_done = 1'b0;
        chk(inj_all == 1'b0 && mid_mode == 2'd2, "R2 one step on done", mid_mode, 2);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            automatic logic [2:0] op = VEC[v][15:13];
            automatic int adv = -1, lim, nline = 0, oread = -1, aclr_at = -1;
            automatic int c_aclr = 0, c_pclr = 0, c_disc = 0, c_lowcp = 0;
            automatic int c_probe = 0, c_skip = 0, c_inc = 0, bad_oh = 0, bad_md = 0;
            run_op(op, VEC[v][12]);
            for (int k = 0; k < NREC; k++) if (adv < 0 && rec_inc[k]) adv = k;
            lim = (adv < 0) ? NREC - 1 : adv;
            for (int k = 0; k <= lim; k++) begin
                c_aclr += rec_aclr[k]; c_pclr += rec_pclr[k]; c_disc += rec_disc[k];
                c_lowcp += (rec_low[k] == 2'd1); c_probe += rec_probe[k];
                c_skip += rec_skip[k]; c_inc += rec_inc[k];
                if (rec_aclr[k] && aclr_at < 0) aclr_at = k;
                if (rec_line[k]) begin
                    nline++;
                    if (nline == 2) oread = k;
                end
                if ($countones(rec_route[k]) != 1) bad_oh++;
                if (rec_mid[k] == 2'd3 || rec_low[k] == 2'd3) bad_md++;
            end
            chk(adv + 1 == int'(VEC[v][11:8]), "R9 instruction length", adv + 1, VEC[v][11:8]);
            chk(c_inc == 1 && adv >= 0 && rec_send[adv] && rec_idec[adv],
                "R9 advance bundle", c_inc, 1);
            chk(c_aclr == int'(VEC[v][7]), "R6 acc clear count", c_aclr, VEC[v][7]);
            chk(c_pclr == int'(VEC[v][6]), "R6 pc clear count", c_pclr, VEC[v][6]);
            chk(c_disc == int'(VEC[v][5:4]), "R7 discard steps", c_disc, VEC[v][5:4]);
            chk(c_lowcp == int'(VEC[v][3]), "R7 lower copy", c_lowcp, VEC[v][3]);
            chk(c_probe == int'(VEC[v][2]), "R8 probe steps", c_probe, VEC[v][2]);
            chk(c_skip == int'(VEC[v][1]), "R8 skip increment", c_skip, VEC[v][1]);
            chk(oread >= 0 && rec_route[oread] == exp_route(op), "R4 operand route",
                (oread >= 0) ? rec_route[oread] : -1, exp_route(op));
            chk(bad_oh == 0, "R5 route one-hot", bad_oh, 0);
            chk(bad_md == 0, "R11 regen mode legal", bad_md, 0);
            if (VEC[v][7] || VEC[v][6]) begin
                automatic int clr_at = aclr_at;
                if (VEC[v][6]) for (int k = 0; k <= lim; k++) if (rec_pclr[k] && clr_at < 0) clr_at = k;
                chk(clr_at >= 0 && clr_at < oread, "R6 clear before operand", clr_at, oread);
            end
            if (VEC[v][1]) chk(rec_inc[adv] && rec_skip[adv], "R8 skip with normal inc", rec_skip[adv], 1);
        end

        // R3: fetch order
        run_op(3'd4, 1'b0);
        chk(rec_inj[0] && rec_route[0] == 5'b00010, "R3 fetch inject", rec_route[0], 2);
        chk(rec_mid[1] == 2'd2 && rec_route[1] == 5'b00010, "R3 fetch address", rec_mid[1], 2);
        chk(rec_line[2] && !rec_inj[2], "R3 fetch read", rec_line[2], 1);
        chk(rec_mid[3] == 2'd1 && rec_mrst[3], "R3 fetch copy-back", rec_mid[3], 1);
        chk(rec_send[4] && !rec_inc[4], "R3 fetch sender release", rec_send[4], 1);
        chk(rec_mid[5] == 2'd2 && rec_route[5] == 5'b00001, "R3 fetch dispatch", rec_route[5], 1);

        // R10: halt
        run_op(3'd7, 1'b1);
        chk(rec_halt[6] == 1'b1, "R10 halt entered", rec_halt[6], 1);
        begin
            automatic int act = 0;
            for (int k = 6; k < NREC; k++) act += rec_inc[k] + rec_inj[k] + rec_line[k] + !rec_halt[k];
            chk(act == 0, "R10 halt frozen", act, 0);
        end
        op_in = 3'd0;
        step_done = 1'b1;
        repeat (3) @(negedge clk);
        chk(halted == 1'b1 && inj_all == 1'b0, "R10 halt holds", halted, 1);
        do_reset();
        @(negedge clk);
        chk(halted == 1'b0 && route == 5'b00001, "R10 reset leaves halt", halted, 0);

        finish_run();
    end
endmodule